// File: doc/BRIEF.md
# Trimmed Reference-Clock Timebase with Match Events

This block keeps a 32-bit time count that advances from a slow reference clock, nominally 32.768 kHz. A 16-bit trim stage divides the reference down before it reaches the counter. A bypass bit lets the counter advance on every reference edge instead. Three compare registers watch the count. Each one produces a single host-clock pulse whenever the count becomes equal to its value.

Software works entirely in the fast host clock domain, through a small word-addressed register port. Writes that must reach the reference domain are carried by a toggle handshake that is synchronised in both directions. These are the counter preset, the trim value, the three compare values, and the run and bypass bits. Each such target has a pending flag in the control word. The flag stays set until the new value is in force on the reference side. Two further bits select oscillator enable and oscillator bypass. They act directly on output pins. A status bit reports the state of an external oscillator-running indication.

Top module: `ref_timebase`

## Requirements
- R1: After reset, every readable location returns 0, apart from the oscillator-running status (control bit 8). No compare pulse is issued.
- R2: The word addresses are: control 0, trim 1, preset 2, compare 0..2 at 3..5, and live count 6. A write to address 1 through 5 sets a pending flag from the next host cycle. So does a write to address 0, for the run and bypass bits. The flags sit in the control word: preset at bit 16, trim at 17, compares at 18..20, run/bypass at 21. Each flag clears once the value has taken effect in the reference domain. After the preset flag clears with the counter stopped, address 6 reads the preset value.
- R3: A write to a target whose pending flag is set is dropped. The earlier value is the one that takes effect and reads back.
- R4: With control bit 0 (run) set, bit 1 (bypass) clear and trim T > 0, the count advances once per T+1 reference cycles.
- R5: With bypass set, or with trim 0, the count advances on every reference cycle.
- R6: Each compare gives a pulse exactly one host cycle wide per equality event. An event occurs when the count becomes equal to the compare value, or when a compare value equal to the current count is loaded. Compares holding the same value pulse in the same host cycle.
- R7: With run clear, the count holds its value.
- R8: A preset that lands on the same reference edge as an increment wins over it. The division phase restarts from zero.
- R9: Control bits 2 (oscillator enable) and 3 (oscillator bypass) drive their output pins from the cycle after the write, with no pending flag. Control bit 8 shows the oscillator-running input after a two-stage synchroniser.
- R10: Addresses 1 to 5 return the last accepted written value. Control bits 0 and 1 return the last accepted run and bypass settings.
- R11: No compare pulse appears without an equality event. In particular, the equal reset values of count and compares produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst | input | 1 | Synchronous active-high reset, host domain; resynchronised into the reference domain |
| rclk | input | 1 | Reference clock (nominally 32.768 kHz) |
| osc_running_i | input | 1 | Oscillator running indication, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| match_pulse | output | 3 | One-cycle compare event pulses, host domain |
| osc_enable_o | output | 1 | Oscillator enable control |
| osc_bypass_o | output | 1 | Select external pin as reference source |

## Verification
Two functions can meet in one reference cycle: a preset arriving from the host, and an increment of the running count. The bench provokes this with bypass set, so an increment falls on every reference edge. It then presets the count to exactly the value of compare 0 while the counter runs. The collision is judged from three observations: compare 0 must fire, the live count read right after the handshake must lie just above the preset, and compare 1, four counts higher, must follow exactly four reference periods later. A second collision puts two compares on one value and checks that both pulses land in the same host cycle.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    // Datapath dimensions
    localparam int CNT_W   = 32;
    localparam int TRIM_W  = 16;
    localparam int N_MATCH = 3;
    localparam int ADDR_W  = 3;

    // Word addresses; compares occupy A_MATCH0 .. A_MATCH0+N_MATCH-1
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_TRIM   = 3'd1;
    localparam logic [ADDR_W-1:0] A_PRESET = 3'd2;
    localparam logic [ADDR_W-1:0] A_MATCH0 = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(3 + N_MATCH);

    // Control word bit positions
    localparam int CB_RUN    = 0;
    localparam int CB_BYP    = 1;
    localparam int CB_OSCEN  = 2;
    localparam int CB_OSCBYP = 3;
    localparam int CB_OSCOK  = 8;
    localparam int CB_BUSY   = 16;

    // Crossing channel indices (pending flag k sits at CB_BUSY+k)
    localparam int CH_PRESET = 0;
    localparam int CH_TRIM   = 1;
    localparam int CH_MATCH0 = 2;
    localparam int CH_CTRL   = 2 + N_MATCH;
    localparam int N_CH      = 3 + N_MATCH;

    // Rate settings carried as one unit into the reference domain
    typedef struct packed {
        logic bypass;
        logic run;
    } rate_ctrl_t;

endpackage

// File: rtl/tcm_sync.sv
module tcm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tcm_xfer.sv
// Carries one host-written value into the reference domain.
// Toggle request out, toggle acknowledge back; host writes while pending are dropped.
module tcm_xfer #(
    parameter int W = 8
) (
    input  logic         hclk,
    input  logic         hrst,
    input  logic         h_wr,
    input  logic [W-1:0] h_data,
    output logic         h_busy,
    output logic [W-1:0] h_hold,
    input  logic         rclk,
    input  logic         rrst,
    output logic [W-1:0] r_val,
    output logic         r_upd
);
    logic req_q;
    logic ack_h;
    logic r_req;
    logic r_seen_q;
    logic ack_q;
    logic cap;

    // Host side
    assign h_busy = req_q ^ ack_h;

    always_ff @(posedge hclk) begin
        if (hrst) begin
            req_q  <= 1'b0;
            h_hold <= '0;
        end else if (h_wr && !h_busy) begin
            req_q  <= ~req_q;
            h_hold <= h_data;
        end
    end

    tcm_sync #(.W(1)) u_ack_sync (
        .clk (hclk),
        .rst (hrst),
        .d   (ack_q),
        .q   (ack_h)
    );

    // Reference side
    tcm_sync #(.W(1)) u_req_sync (
        .clk (rclk),
        .rst (rrst),
        .d   (req_q),
        .q   (r_req)
    );

    assign cap = r_req ^ r_seen_q;

    // h_hold is frozen while the request is outstanding, so it is stable here.
    // The acknowledge toggles one edge after capture, on the edge the consumer applies r_upd.
    always_ff @(posedge rclk) begin
        if (rrst) begin
            r_seen_q <= 1'b0;
            r_upd    <= 1'b0;
            r_val    <= '0;
            ack_q    <= 1'b0;
        end else begin
            r_seen_q <= r_req;
            r_upd    <= cap;
            ack_q    <= r_seen_q;
            if (cap) begin
                r_val <= h_hold;
            end
        end
    end
endmodule

// File: rtl/tcm_evt.sv
// Turns a reference-domain event toggle into a one-cycle host pulse.
module tcm_evt (
    input  logic hclk,
    input  logic hrst,
    input  logic tgl,
    output logic pulse
);
    logic tgl_h;
    logic tgl_prev;

    tcm_sync #(.W(1)) u_evt_sync (
        .clk (hclk),
        .rst (hrst),
        .d   (tgl),
        .q   (tgl_h)
    );

    always_ff @(posedge hclk) begin
        if (hrst) begin
            tgl_prev <= 1'b0;
            pulse    <= 1'b0;
        end else begin
            tgl_prev <= tgl_h;
            pulse    <= tgl_h ^ tgl_prev;
        end
    end
endmodule

// File: rtl/tcm_core.sv
// Reference-domain datapath: trim prescaler, time counter, compare events.
module tcm_core #(
    parameter int CNT_W  = 32,
    parameter int TRIM_W = 16,
    parameter int N_M    = 3
) (
    input  logic                      rclk,
    input  logic                      rrst,
    input  logic                      load_upd,
    input  logic [CNT_W-1:0]          load_val,
    input  logic                      trim_upd,
    input  logic [TRIM_W-1:0]         trim_val,
    input  logic                      ctrl_upd,
    input  logic                      run,
    input  logic                      bypass,
    input  logic [N_M-1:0]            m_upd,
    input  logic [N_M-1:0][CNT_W-1:0] m_val,
    output logic [CNT_W-1:0]          cnt_gray,
    output logic [N_M-1:0]            evt_tgl
);
    logic [TRIM_W-1:0] pre_q;
    logic              wrap;
    logic              tick;
    logic              restart;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;

    // Prescaler counts 0..trim; trim 0 wraps every cycle
    assign wrap    = (pre_q == trim_val);
    assign tick    = run && (bypass || wrap);
    assign restart = load_upd || trim_upd || ctrl_upd || !run;

    always_ff @(posedge rclk) begin
        if (rrst || restart || wrap) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // A preset beats a coincident increment
    assign cnt_d = load_upd ? load_val : (cnt_q + CNT_W'(tick));

    // Gray mirror registered from the same next value, so it moves on the same edge as cnt_q
    always_ff @(posedge rclk) begin
        if (rrst) begin
            cnt_q    <= '0;
            cnt_gray <= '0;
        end else begin
            cnt_q    <= cnt_d;
            cnt_gray <= cnt_d ^ (cnt_d >> 1);
        end
    end

    // Compare events: the count becomes equal, or an equal value is loaded
    for (genvar i = 0; i < N_M; i++) begin : g_cmp
        logic eq;
        logic eq_prev;
        logic fire;

        assign eq   = (cnt_q == m_val[i]);
        assign fire = eq && (!eq_prev || m_upd[i]);

        always_ff @(posedge rclk) begin
            if (rrst) begin
                eq_prev    <= 1'b1;
                evt_tgl[i] <= 1'b0;
            end else begin
                eq_prev    <= eq;
                evt_tgl[i] <= evt_tgl[i] ^ fire;
            end
        end
    end
endmodule

// File: rtl/ref_timebase.sv
module ref_timebase
    import tcm_pkg::*;
(
    input  logic                      hclk,
    input  logic                      hrst,
    input  logic                      rclk,
    input  logic                      osc_running_i,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [CNT_W-1:0]          reg_wdata,
    output logic [CNT_W-1:0]          reg_rdata,
    output logic [N_MATCH-1:0]        match_pulse,
    output logic                      osc_enable_o,
    output logic                      osc_bypass_o
);
    // Reference-domain reset, resynchronised from the host reset
    logic rrst_m;
    logic rrst;

    always_ff @(posedge rclk) begin
        rrst_m <= hrst;
        rrst   <= rrst_m;
    end

    // Host-side state
    logic [N_CH-1:0]                 busy_vec;
    logic [CNT_W-1:0]                preset_hold;
    logic [TRIM_W-1:0]               trim_hold;
    rate_ctrl_t                      ctrl_hold;
    logic [N_MATCH-1:0][CNT_W-1:0]   match_hold;
    logic                            osc_ok_h;
    logic [CNT_W-1:0]                gray_h;
    logic [CNT_W-1:0]                count_h;

    // Reference-side values
    logic [CNT_W-1:0]                r_preset;
    logic                            r_preset_upd;
    logic [TRIM_W-1:0]               r_trim;
    logic                            r_trim_upd;
    rate_ctrl_t                      r_ctrl;
    logic                            r_ctrl_upd;
    logic [N_MATCH-1:0][CNT_W-1:0]   r_match;
    logic [N_MATCH-1:0]              r_match_upd;
    logic [CNT_W-1:0]                r_gray;
    logic [N_MATCH-1:0]              r_evt;

    // Write decode
    logic       wr_ctrl;
    logic       wr_trim;
    logic       wr_preset;
    rate_ctrl_t ctrl_wdata;

    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign wr_trim   = reg_wr && (reg_addr == A_TRIM);
    assign wr_preset = reg_wr && (reg_addr == A_PRESET);

    assign ctrl_wdata.run    = reg_wdata[CB_RUN];
    assign ctrl_wdata.bypass = reg_wdata[CB_BYP];

    // Oscillator controls do not cross; they apply on every control write
    always_ff @(posedge hclk) begin
        if (hrst) begin
            osc_enable_o <= 1'b0;
            osc_bypass_o <= 1'b0;
        end else if (wr_ctrl) begin
            osc_enable_o <= reg_wdata[CB_OSCEN];
            osc_bypass_o <= reg_wdata[CB_OSCBYP];
        end
    end

    tcm_sync #(.W(1)) u_osc_sync (
        .clk (hclk),
        .rst (hrst),
        .d   (osc_running_i),
        .q   (osc_ok_h)
    );

    // Crossing channels
    tcm_xfer #(.W(CNT_W)) u_x_preset (
        .hclk   (hclk),
        .hrst   (hrst),
        .h_wr   (wr_preset),
        .h_data (reg_wdata),
        .h_busy (busy_vec[CH_PRESET]),
        .h_hold (preset_hold),
        .rclk   (rclk),
        .rrst   (rrst),
        .r_val  (r_preset),
        .r_upd  (r_preset_upd)
    );

    tcm_xfer #(.W(TRIM_W)) u_x_trim (
        .hclk   (hclk),
        .hrst   (hrst),
        .h_wr   (wr_trim),
        .h_data (reg_wdata[TRIM_W-1:0]),
        .h_busy (busy_vec[CH_TRIM]),
        .h_hold (trim_hold),
        .rclk   (rclk),
        .rrst   (rrst),
        .r_val  (r_trim),
        .r_upd  (r_trim_upd)
    );

    tcm_xfer #(.W($bits(rate_ctrl_t))) u_x_ctrl (
        .hclk   (hclk),
        .hrst   (hrst),
        .h_wr   (wr_ctrl),
        .h_data (ctrl_wdata),
        .h_busy (busy_vec[CH_CTRL]),
        .h_hold (ctrl_hold),
        .rclk   (rclk),
        .rrst   (rrst),
        .r_val  (r_ctrl),
        .r_upd  (r_ctrl_upd)
    );

    for (genvar i = 0; i < N_MATCH; i++) begin : g_match
        logic wr_m;

        assign wr_m = reg_wr && (reg_addr == ADDR_W'(A_MATCH0 + i));

        tcm_xfer #(.W(CNT_W)) u_x_match (
            .hclk   (hclk),
            .hrst   (hrst),
            .h_wr   (wr_m),
            .h_data (reg_wdata),
            .h_busy (busy_vec[CH_MATCH0 + i]),
            .h_hold (match_hold[i]),
            .rclk   (rclk),
            .rrst   (rrst),
            .r_val  (r_match[i]),
            .r_upd  (r_match_upd[i])
        );

        tcm_evt u_evt (
            .hclk  (hclk),
            .hrst  (hrst),
            .tgl   (r_evt[i]),
            .pulse (match_pulse[i])
        );
    end

    // Reference-domain datapath
    tcm_core #(
        .CNT_W  (CNT_W),
        .TRIM_W (TRIM_W),
        .N_M    (N_MATCH)
    ) u_core (
        .rclk     (rclk),
        .rrst     (rrst),
        .load_upd (r_preset_upd),
        .load_val (r_preset),
        .trim_upd (r_trim_upd),
        .trim_val (r_trim),
        .ctrl_upd (r_ctrl_upd),
        .run      (r_ctrl.run),
        .bypass   (r_ctrl.bypass),
        .m_upd    (r_match_upd),
        .m_val    (r_match),
        .cnt_gray (r_gray),
        .evt_tgl  (r_evt)
    );

    // Count mirror into the host domain, Gray coded
    tcm_sync #(.W(CNT_W)) u_cnt_sync (
        .clk (hclk),
        .rst (hrst),
        .d   (r_gray),
        .q   (gray_h)
    );

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            count_h[i] = ^(gray_h >> i);
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata[CB_RUN]           = ctrl_hold.run;
            reg_rdata[CB_BYP]           = ctrl_hold.bypass;
            reg_rdata[CB_OSCEN]         = osc_enable_o;
            reg_rdata[CB_OSCBYP]        = osc_bypass_o;
            reg_rdata[CB_OSCOK]         = osc_ok_h;
            reg_rdata[CB_BUSY +: N_CH]  = busy_vec;
        end else if (reg_addr == A_TRIM) begin
            reg_rdata = CNT_W'(trim_hold);
        end else if (reg_addr == A_PRESET) begin
            reg_rdata = preset_hold;
        end else if (reg_addr == A_COUNT) begin
            reg_rdata = count_h;
        end
        for (int i = 0; i < N_MATCH; i++) begin
            if (reg_addr == ADDR_W'(A_MATCH0 + i)) begin
                reg_rdata = match_hold[i];
            end
        end
    end
endmodule

// File: rtl/ref_timebase_chk.sv
module ref_timebase_chk
    import tcm_pkg::*;
(
    input logic                  hclk,
    input logic                  hrst,
    input logic                  reg_wr,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [CNT_W-1:0]      reg_wdata,
    input logic [N_MATCH-1:0]    match_pulse,
    input logic                  osc_enable_o,
    input logic [N_CH-1:0]       busy_vec,
    input logic [CNT_W-1:0]      preset_hold
);
    // R2: a preset write leaves its pending flag set on the next cycle
    a_r2_preset_pending: assert property (@(posedge hclk) disable iff (hrst)
        (reg_wr && reg_addr == A_PRESET) |=> busy_vec[CH_PRESET]);

    // R2: same for the trim target
    a_r2_trim_pending: assert property (@(posedge hclk) disable iff (hrst)
        (reg_wr && reg_addr == A_TRIM) |=> busy_vec[CH_TRIM]);

    // R3: the held preset cannot change while its transfer is outstanding
    a_r3_hold_frozen: assert property (@(posedge hclk) disable iff (hrst)
        busy_vec[CH_PRESET] |=> $stable(preset_hold));

    // R6: no compare pulse lasts two cycles
    a_r6_single_cycle: assert property (@(posedge hclk) disable iff (hrst)
        (match_pulse != '0) |=> ((match_pulse & $past(match_pulse)) == '0));

    // R9: oscillator enable follows the written bit one cycle later
    a_r9_osc_follow: assert property (@(posedge hclk) disable iff (hrst)
        (reg_wr && reg_addr == A_CTRL) |=> (osc_enable_o == $past(reg_wdata[CB_OSCEN])));
endmodule

bind ref_timebase ref_timebase_chk u_chk (
    .hclk         (hclk),
    .hrst         (hrst),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .match_pulse  (match_pulse),
    .osc_enable_o (osc_enable_o),
    .busy_vec     (busy_vec),
    .preset_hold  (preset_hold)
);

// File: tb/ref_timebase_bench.sv
module ref_timebase_bench;
    logic        hclk;
    logic        rclk;
    logic        hrst;
    logic        osc_running_i;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [2:0]  match_pulse;
    logic        osc_enable_o;
    logic        osc_bypass_o;

    int vecs  = 0;
    int fails = 0;
    int cyc   = 0;
    int last_pulse = 0;
    bit done = 0;

    // Scoreboard of expected compare events: index, gap in host cycles (-1 = any), tag
    int    q_idx[$];
    int    q_gap[$];
    string q_tag[$];

    ref_timebase u_ref_timebase (
        .hclk          (hclk),
        .hrst          (hrst),
        .rclk          (rclk),
        .osc_running_i (osc_running_i),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .match_pulse   (match_pulse),
        .osc_enable_o  (osc_enable_o),
        .osc_bypass_o  (osc_bypass_o)
    );

    // 250 MHz host clock; reference period = 10 host periods, offset from host edges
    initial begin
        hclk = 0;
        forever #2 hclk = ~hclk;
    end
    initial begin
        rclk = 0;
        #1;
        forever #20 rclk = ~rclk;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vecs++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge hclk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge hclk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge hclk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] c;
        c = '1;
        for (int i = 0; i < 1000; i++) begin
            rd(3'd0, c);
            if (c[21:16] == 6'd0) break;
        end
        chk(tag, {26'd0, c[21:16]}, 32'd0);
    endtask

    task automatic expect_evt(input int idx, input int gap, input string tag);
        q_idx.push_back(idx);
        q_gap.push_back(gap);
        q_tag.push_back(tag);
    endtask

    task automatic drain(input string tag, input int limit);
        int n;
        n = 0;
        while (q_idx.size() != 0 && n < limit) begin
            @(negedge hclk);
            n++;
        end
        chk(tag, q_idx.size(), 0);
    endtask

    // Monitor: pops expected events as the design produces pulses
    always @(negedge hclk) begin
        int    e_i;
        int    e_g;
        string t;
        cyc++;
        if (!hrst) begin
            for (int i = 0; i < 3; i++) begin
                if (match_pulse[i]) begin
                    vecs++;
                    if (q_idx.size() == 0) begin
                        fails++;
                        $display("FAIL R11: unexpected pulse on compare %0d, expected none", i);
                    end else begin
                        e_i = q_idx.pop_front();
                        e_g = q_gap.pop_front();
                        t   = q_tag.pop_front();
                        if (e_i != i || (e_g >= 0 && (cyc - last_pulse) != e_g)) begin
                            fails++;
                            $display("FAIL %s: compare %0d gap %0d, expected compare %0d gap %0d",
                                     t, i, cyc - last_pulse, e_i, e_g);
                        end
                    end
                    last_pulse = cyc;
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] d2;
        hrst = 1'b1;
        osc_running_i = 1'b0;
        reg_wr = 1'b0;
        reg_addr = 3'd0;
        reg_wdata = '0;
        repeat (60) @(negedge hclk);
        hrst = 1'b0;
        repeat (40) @(negedge hclk);

        // R1: reset state
        rd(3'd0, d); chk("R1 control word", d, 32'h0);
        rd(3'd6, d); chk("R1 count", d, 32'h0);
        rd(3'd3, d); chk("R1 compare0", d, 32'h0);
        chk("R1 pulses", {29'd0, match_pulse}, 32'h0);
        repeat (100) @(negedge hclk);
        // R11: the monitor reports any pulse seen so far

        // R9: oscillator controls and status
        osc_running_i = 1'b1;
        repeat (5) @(negedge hclk);
        wr(3'd0, 32'h0000_000C);
        chk("R9 osc enable pin", {31'd0, osc_enable_o}, 32'd1);
        chk("R9 osc bypass pin", {31'd0, osc_bypass_o}, 32'd1);
        rd(3'd0, d); chk("R9 osc running status", {31'd0, d[8]}, 32'd1);
        chk("R9 osc bits readback", {28'd0, d[3:0]}, 32'hC);
        wait_idle("R2 control pending clears");

        // R2: preset pending flag, then value in force
        wr(3'd2, 32'd100);
        rd(3'd0, d); chk("R2 preset pending set", {31'd0, d[16]}, 32'd1);
        wait_idle("R2 preset pending clears");
        rd(3'd6, d); chk("R2 count after preset", d, 32'd100);

        // R3: second write while pending is dropped
        wr(3'd2, 32'd200);
        wr(3'd2, 32'd300);
        wait_idle("R3 pending clears");
        rd(3'd6, d); chk("R3 count keeps first preset", d, 32'd200);
        rd(3'd2, d); chk("R3 preset readback", d, 32'd200);

        // R7: stopped counter holds
        repeat (300) @(negedge hclk);
        rd(3'd6, d); chk("R7 count holds while stopped", d, 32'd200);

        // R6: loading a compare equal to the current count fires once
        expect_evt(2, -1, "R6 equal load");
        wr(3'd5, 32'd200);
        wait_idle("R6 pending clears");
        drain("R6 equal-load event", 2000);

        // R4: trim 3 -> 4 reference cycles per count; 5 counts = 200 host cycles
        wr(3'd1, 32'd3);
        wr(3'd3, 32'd210);
        wr(3'd4, 32'd215);
        wr(3'd2, 32'd205);
        wait_idle("R4 setup pending clears");
        rd(3'd1, d); chk("R10 trim readback", d, 32'd3);
        rd(3'd4, d); chk("R10 compare1 readback", d, 32'd215);
        expect_evt(0, -1, "R4 first compare");
        expect_evt(1, 200, "R4 trim spacing");
        wr(3'd0, 32'h0000_000D);
        drain("R4 events", 20000);
        wr(3'd0, 32'h0000_000C);
        wait_idle("R7 stop pending clears");
        rd(3'd6, d);
        repeat (200) @(negedge hclk);
        rd(3'd6, d2); chk("R7 count frozen after stop", d2, d);

        // R5: bypass with trim 3 -> one count per reference cycle
        wr(3'd3, 32'd303);
        wr(3'd4, 32'd310);
        wr(3'd2, 32'd300);
        wait_idle("R5 setup pending clears");
        expect_evt(0, -1, "R5 bypass first");
        expect_evt(1, 70, "R5 bypass spacing");
        wr(3'd0, 32'h0000_000F);
        drain("R5 bypass events", 20000);
        wr(3'd0, 32'h0000_000C);
        wait_idle("R5 stop pending clears");

        // R5: trim 0 behaves like bypass
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd402);
        wr(3'd4, 32'd406);
        wr(3'd2, 32'd400);
        wait_idle("R5 trim0 setup pending clears");
        expect_evt(0, -1, "R5 trim0 first");
        expect_evt(1, 40, "R5 trim0 spacing");
        wr(3'd0, 32'h0000_000D);
        drain("R5 trim0 events", 20000);
        wr(3'd0, 32'h0000_000C);
        wait_idle("R5 trim0 stop pending clears");

        // R6: two compares on one value pulse in the same host cycle
        wr(3'd3, 32'd498);
        wr(3'd4, 32'd500);
        wr(3'd5, 32'd500);
        wr(3'd2, 32'd495);
        wait_idle("R6 setup pending clears");
        expect_evt(0, -1, "R6 lead compare");
        expect_evt(1, 20, "R6 shared value first");
        expect_evt(2, 0, "R6 shared value same cycle");
        wr(3'd0, 32'h0000_000D);
        drain("R6 shared events", 20000);
        wr(3'd0, 32'h0000_000C);
        wait_idle("R6 stop pending clears");

        // R8: preset lands on an increment edge (bypass, running)
        wr(3'd3, 32'd1000);
        wr(3'd4, 32'd1004);
        wr(3'd2, 32'd600);
        wait_idle("R8 setup pending clears");
        wr(3'd0, 32'h0000_000F);
        wait_idle("R8 run pending clears");
        expect_evt(0, -1, "R8 preset hits compare");
        expect_evt(1, 40, "R8 counting resumes from preset");
        wr(3'd2, 32'd1000);
        wait_idle("R8 preset pending clears");
        rd(3'd6, d);
        chk("R8 count just past preset", {31'd0, (d >= 32'd1000 && d <= 32'd1010)}, 32'd1);
        drain("R8 events", 2000);
        wr(3'd0, 32'h0000_000C);
        wait_idle("R8 stop pending clears");

        repeat (200) @(negedge hclk);
        chk("R11 no leftover expected events", q_idx.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule